// File: doc/BRIEF.md
# PLL Frequency Crawl Sequencer

This block retunes a clock PLL that is already running. It takes a target configuration made of a VCO frequency, an output clock frequency and a reference frequency, all in MHz. It compares that target with the configuration it last applied. From the comparison it picks one of three actions: do nothing, crawl, or disable and relight. It then issues the writes to the PLL control register that the chosen action needs.

A crawl keeps the PLL enabled the whole time. It loads the new multiplier and raises a frequency-change request. It waits for the PLL to report both lock and acknowledge, then drops the request. If the change is not eligible for a crawl, the block switches the PLL off (when it was on) and turns it back on with the new multiplier. It then waits for lock.

A host starts an operation with a one-cycle `start` pulse. It watches `busy`, a one-cycle `done` and a sticky `err`. The control word is written through a plain write strobe. The lock and acknowledge status bits come back as two inputs.

Top module: `pll_crawl_seq`

## Requirements
- R1: Control words written to the PLL carry enable at bit 31, frequency-change request at bit 23 and the multiplier in bits 7:0. All other bits are 0.
- R2: The multiplier is the target VCO divided by the target reference, rounded half up, keeping the low 8 bits. A zero reference gives 0.
- R3: A crawl writes exactly three words: enable|ratio, then enable|request|ratio, then enable|ratio. Enable is set in every crawl word.
- R4: During a crawl the request is dropped only after lock and acknowledge have been seen high together, unless the timeout expires.
- R5: If the awaited status does not appear within CLK_MHZ*TIMEOUT_US cycles, `err` is set. For a crawl the request is still dropped, and the operation completes.
- R6: A crawl is used only when `crawl_en` is set, the current and target VCO are both nonzero and differ, the reference is unchanged, and the rounded VCO/clock divider is equal for old and new.
- R7: When the target VCO equals the current VCO, no write is issued.
- R8: Otherwise the full path runs. It writes 0 if the current VCO is nonzero. If the target VCO is nonzero, it then writes enable|ratio and waits for lock, with the timeout of R5 applied.
- R9: At `done` the target becomes the current configuration, including after a timeout; `cur_vco` shows it.
- R10: `busy` is high from the cycle after an accepted start until `done`. `done` is a single-cycle pulse in the cycle `busy` falls.
- R11: A `start` that arrives while `busy` is ignored. It causes no second operation, and its target values are not used.
- R12: `err` stays set after `done` and is cleared when the next start is accepted.
- R13: After reset, `busy`, `done`, `err` and the write strobe are low and `cur_vco` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to apply the target |
| crawl_en | input | 1 | Allows crawling for this request |
| tgt_vco | input | FREQ_W | Target VCO frequency, MHz |
| tgt_cdclk | input | FREQ_W | Target output clock frequency, MHz |
| tgt_ref | input | FREQ_W | Target reference frequency, MHz |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout flag |
| cur_vco | output | FREQ_W | VCO frequency last applied |
| pll_wr_en | output | 1 | Write strobe for the PLL control register |
| pll_wr_data | output | 32 | Control word being written |
| pll_lock | input | 1 | Lock status read from the control register |
| pll_ack | input | 1 | Frequency-change acknowledge read from the control register |

## Verification
A wrong path decision shows at the port as a different write count or word sequence within two cycles of `start`. For example, a zero written where a crawl was due, or a write issued when the VCO is unchanged. A wrong stored configuration is silent until the next request, which then takes the wrong path. For that reason the sweep chains every ordered pair of configurations so that each operation depends on the one before it. A timer or handshake fault shows as `done` arriving before the status handshake or far from the timeout, or as `err` in the wrong state.

// File: rtl/pll_crawl_pkg.sv
package pll_crawl_pkg;

    localparam int PLL_EN_BIT   = 31;
    localparam int PLL_REQ_BIT  = 23;
    localparam int MULT_W       = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_REQ,
        ST_WAIT_ACK,
        ST_RELIGHT,
        ST_WAIT_LOCK
    } seq_state_e;

    typedef enum logic [1:0] {
        PATH_NONE,
        PATH_CRAWL,
        PATH_FULL
    } crawl_path_e;

    // Build a control word from its fields; unused bits stay zero.
    function automatic logic [31:0] ctl_word(input logic en, input logic req,
                                             input logic [MULT_W-1:0] mult);
        logic [31:0] w;
        w = '0;
        w[PLL_EN_BIT]  = en;
        w[PLL_REQ_BIT] = req;
        w[MULT_W-1:0]  = mult;
        return w;
    endfunction

endpackage

// File: rtl/crawl_rdiv.sv
// Rounded (half up) unsigned division; a zero divisor yields zero.
module crawl_rdiv #(
    parameter int NUM_W = 16,
    parameter int DEN_W = 16,
    parameter int Q_W   = 16
) (
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [Q_W-1:0]   quo
);
    localparam int SW = ((NUM_W > DEN_W) ? NUM_W : DEN_W) + 1;

    logic [SW-1:0] den_w;
    logic [SW-1:0] sum_w;
    logic [SW-1:0] q_w;

    assign den_w = SW'(den);
    assign sum_w = SW'(num) + (den_w >> 1);
    assign q_w   = (den_w == '0) ? '0 : (sum_w / den_w);
    assign quo   = Q_W'(q_w);

endmodule

// File: rtl/crawl_eligibility.sv
// Chooses how a configuration change is applied.
module crawl_eligibility
    import pll_crawl_pkg::*;
#(
    parameter int FREQ_W = 16
) (
    input  logic              crawl_en,
    input  logic [FREQ_W-1:0] cur_vco,
    input  logic [FREQ_W-1:0] cur_cdclk,
    input  logic [FREQ_W-1:0] cur_ref,
    input  logic [FREQ_W-1:0] new_vco,
    input  logic [FREQ_W-1:0] new_cdclk,
    input  logic [FREQ_W-1:0] new_ref,
    output crawl_path_e       path
);
    logic [FREQ_W-1:0] cur_div;
    logic [FREQ_W-1:0] new_div;

    crawl_rdiv #(.NUM_W(FREQ_W), .DEN_W(FREQ_W), .Q_W(FREQ_W)) u_cur_div (
        .num(cur_vco), .den(cur_cdclk), .quo(cur_div)
    );

    crawl_rdiv #(.NUM_W(FREQ_W), .DEN_W(FREQ_W), .Q_W(FREQ_W)) u_new_div (
        .num(new_vco), .den(new_cdclk), .quo(new_div)
    );

    logic both_on;
    logic same_div;

    always_comb begin
        both_on  = (cur_vco != '0) && (new_vco != '0);
        same_div = (cur_div == new_div);
        if (cur_vco == new_vco) begin
            path = PATH_NONE;
        end else if (crawl_en && both_on && (cur_ref == new_ref) && same_div) begin
            path = PATH_CRAWL;
        end else begin
            path = PATH_FULL;
        end
    end

endmodule

// File: rtl/pll_crawl_seq.sv
module pll_crawl_seq
    import pll_crawl_pkg::*;
#(
    parameter int FREQ_W     = 16,
    parameter int CLK_MHZ    = 200,
    parameter int TIMEOUT_US = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              crawl_en,
    input  logic [FREQ_W-1:0] tgt_vco,
    input  logic [FREQ_W-1:0] tgt_cdclk,
    input  logic [FREQ_W-1:0] tgt_ref,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [FREQ_W-1:0] cur_vco,
    output logic              pll_wr_en,
    output logic [31:0]       pll_wr_data,
    input  logic              pll_lock,
    input  logic              pll_ack
);
    localparam int TMO_CYC = CLK_MHZ * TIMEOUT_US;
    localparam int TMR_W   = $clog2(TMO_CYC + 1);

    typedef struct packed {
        seq_state_e        st;
        crawl_path_e       path;
        logic              busy;
        logic              done;
        logic              err;
        logic              wr_en;
        logic [31:0]       wr_data;
        logic [TMR_W-1:0]  tmr;
        logic              new_crawl_en;
        logic [FREQ_W-1:0] new_vco;
        logic [FREQ_W-1:0] new_cdclk;
        logic [FREQ_W-1:0] new_ref;
        logic [FREQ_W-1:0] now_vco;
        logic [FREQ_W-1:0] now_cdclk;
        logic [FREQ_W-1:0] now_ref;
    } seq_regs_t;

    seq_regs_t q, d;

    crawl_path_e       path_w;
    logic [MULT_W-1:0] mult_w;
    logic              tmo_w;

    crawl_rdiv #(.NUM_W(FREQ_W), .DEN_W(FREQ_W), .Q_W(MULT_W)) u_mult (
        .num(q.new_vco), .den(q.new_ref), .quo(mult_w)
    );

    crawl_eligibility #(.FREQ_W(FREQ_W)) u_elig (
        .crawl_en (q.new_crawl_en),
        .cur_vco  (q.now_vco),
        .cur_cdclk(q.now_cdclk),
        .cur_ref  (q.now_ref),
        .new_vco  (q.new_vco),
        .new_cdclk(q.new_cdclk),
        .new_ref  (q.new_ref),
        .path     (path_w)
    );

    assign tmo_w = (q.tmr == TMR_W'(TMO_CYC - 1));

    always_comb begin
        logic fin;
        fin       = 1'b0;
        d         = q;
        d.done    = 1'b0;
        d.wr_en   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st           = ST_PLAN;
                    d.busy         = 1'b1;
                    d.err          = 1'b0;
                    d.new_crawl_en = crawl_en;
                    d.new_vco      = tgt_vco;
                    d.new_cdclk    = tgt_cdclk;
                    d.new_ref      = tgt_ref;
                end
            end
            ST_PLAN: begin
                d.path = path_w;
                unique case (path_w)
                    PATH_CRAWL: begin
                        d.wr_en   = 1'b1;
                        d.wr_data = ctl_word(1'b1, 1'b0, mult_w);
                        d.st      = ST_REQ;
                    end
                    PATH_FULL: begin
                        d.wr_en = 1'b1;
                        if (q.now_vco != '0) begin
                            d.wr_data = '0;
                            if (q.new_vco != '0) begin
                                d.st = ST_RELIGHT;
                            end else begin
                                fin = 1'b1;
                            end
                        end else begin
                            d.wr_data = ctl_word(1'b1, 1'b0, mult_w);
                            d.tmr     = '0;
                            d.st      = ST_WAIT_LOCK;
                        end
                    end
                    default: fin = 1'b1;
                endcase
            end
            ST_REQ: begin
                d.wr_en   = 1'b1;
                d.wr_data = ctl_word(1'b1, 1'b1, mult_w);
                d.tmr     = '0;
                d.st      = ST_WAIT_ACK;
            end
            ST_WAIT_ACK: begin
                if ((pll_lock && pll_ack) || tmo_w) begin
                    d.wr_en   = 1'b1;
                    d.wr_data = ctl_word(1'b1, 1'b0, mult_w);
                    d.err     = !(pll_lock && pll_ack);
                    fin       = 1'b1;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            ST_RELIGHT: begin
                d.wr_en   = 1'b1;
                d.wr_data = ctl_word(1'b1, 1'b0, mult_w);
                d.tmr     = '0;
                d.st      = ST_WAIT_LOCK;
            end
            ST_WAIT_LOCK: begin
                if (pll_lock || tmo_w) begin
                    d.err = !pll_lock;
                    fin   = 1'b1;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (fin) begin
            d.st        = ST_IDLE;
            d.busy      = 1'b0;
            d.done      = 1'b1;
            d.now_vco   = q.new_vco;
            d.now_cdclk = q.new_cdclk;
            d.now_ref   = q.new_ref;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy        = q.busy;
    assign done        = q.done;
    assign err         = q.err;
    assign cur_vco     = q.now_vco;
    assign pll_wr_en   = q.wr_en;
    assign pll_wr_data = q.wr_data;

    // R10: completion coincides with busy falling
    a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (!q.busy && $past(q.busy)));

    // R11: the latched target does not move while an operation runs
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start) |=> $stable(q.new_vco));

    // R3: every crawl write keeps the PLL enabled
    a_r3_crawl_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wr_en && q.path == PATH_CRAWL) |-> q.wr_data[PLL_EN_BIT]);

    // R4: a successful crawl drops the request only after lock and ack
    a_r4_ack_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wr_en && q.path == PATH_CRAWL && q.st == ST_IDLE && !q.err)
        |-> ($past(pll_lock) && $past(pll_ack)));

    // R5: the wait timer never passes the timeout window
    a_r5_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.tmr < TMR_W'(TMO_CYC));

    // R12: the error flag can only rise together with completion
    a_r12_err_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> q.done);

    // R7: an unchanged VCO produces no write
    a_r7_no_write_when_same: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> (q.path != PATH_NONE));

endmodule

// File: tb/pll_crawl_seq_tb.sv
`timescale 1ns/1ps
module pll_crawl_seq_tb_top;

    localparam int FW      = 16;
    localparam int CLK_MHZ = 200;
    localparam int TUS     = 1;
    localparam int TMO     = CLK_MHZ * TUS;
    localparam int RDLY    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          crawl_en = 1'b0;
    logic [FW-1:0] tgt_vco = '0;
    logic [FW-1:0] tgt_cdclk = '0;
    logic [FW-1:0] tgt_ref = '0;
    logic          busy, done, err;
    logic [FW-1:0] cur_vco;
    logic          pll_wr_en;
    logic [31:0]   pll_wr_data;
    logic          lock_w, ack_w;

    always #2.5 clk = ~clk;

    pll_crawl_seq #(.FREQ_W(FW), .CLK_MHZ(CLK_MHZ), .TIMEOUT_US(TUS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .crawl_en(crawl_en),
        .tgt_vco(tgt_vco), .tgt_cdclk(tgt_cdclk), .tgt_ref(tgt_ref),
        .busy(busy), .done(done), .err(err), .cur_vco(cur_vco),
        .pll_wr_en(pll_wr_en), .pll_wr_data(pll_wr_data),
        .pll_lock(lock_w), .pll_ack(ack_w)
    );

    // Behavioural PLL: keeps enable, request and multiplier; status after RDLY cycles.
    logic [31:0] pll_reg;
    int          rcnt;
    logic        stall = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            pll_reg <= '0;
            rcnt    <= 0;
        end else if (pll_wr_en) begin
            pll_reg <= pll_wr_data & 32'h8080_00FF;
            rcnt    <= 0;
        end else if (rcnt < 100) begin
            rcnt <= rcnt + 1;
        end
    end

    assign lock_w = pll_reg[31] && (rcnt >= RDLY) && !stall;
    assign ack_w  = pll_reg[23] && (rcnt >= RDLY) && !stall;

    // Write logger
    logic [31:0] wlog [8];
    int          wcnt;
    logic        log_clr = 1'b0;

    always @(posedge clk) begin
        if (log_clr) begin
            wcnt <= 0;
        end else if (pll_wr_en) begin
            if (wcnt < 8) wlog[wcnt] <= pll_wr_data;
            wcnt <= wcnt + 1;
        end
    end

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    int m_vco = 0, m_cdclk = 0, m_ref = 0;

    int cv [8] = '{0, 1920, 2112, 2304, 1920, 2112, 2160, 1932};
    int cc [8] = '{0,  480,  528,  576,  960,  528,  540,  483};
    int cr [8] = '{19,  24,   24,   24,   24,   19,   24,   24};

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int rdiv(input int a, input int b);
        return (b == 0) ? 0 : (a + b / 2) / b;
    endfunction

    task automatic run_op(input int vco, input int cdclk, input int rf,
                          input bit en, input bit stall_i, input bit dup);
        int          ratio;
        int          ne;
        int          lat;
        int          bad;
        bit          crawl;
        bit          exp_err;
        string       tag;
        logic [31:0] e [3];
        ratio   = rdiv(vco, rf) & 255;
        ne      = 0;
        crawl   = 1'b0;
        exp_err = 1'b0;
        if (vco == m_vco) begin
            tag = "R7";
        end else if (en && m_vco != 0 && vco != 0 && rf == m_ref &&
                     rdiv(m_vco, m_cdclk) == rdiv(vco, cdclk)) begin
            tag   = "R6/R3";
            crawl = 1'b1;
            e[0]  = 32'h8000_0000 | 32'(ratio);
            e[1]  = 32'h8080_0000 | 32'(ratio);
            e[2]  = 32'h8000_0000 | 32'(ratio);
            ne    = 3;
            exp_err = stall_i;
        end else begin
            tag = "R6/R8";
            if (m_vco != 0) begin e[ne] = 32'h0; ne++; end
            if (vco != 0) begin e[ne] = 32'h8000_0000 | 32'(ratio); ne++; end
            exp_err = stall_i && (vco != 0);
        end

        @(negedge clk);
        log_clr   = 1'b1;
        stall     = stall_i;
        crawl_en  = en;
        tgt_vco   = 16'(vco);
        tgt_cdclk = 16'(cdclk);
        tgt_ref   = 16'(rf);
        start     = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        start   = 1'b0;
        chk(busy == 1'b1, "R10", "busy after start", longint'(busy), 1);
        chk(err == 1'b0, "R12", "err cleared by start", longint'(err), 0);
        lat = 1;
        while (!done && lat < 2000) begin
            if (dup && lat == 2) begin
                start   = 1'b1;
                tgt_vco = 16'(vco + 96);
            end else begin
                start   = 1'b0;
                tgt_vco = 16'(vco);
            end
            @(negedge clk);
            lat++;
        end
        start   = 1'b0;
        tgt_vco = 16'(vco);
        chk(done == 1'b1, "R10", "done reached", longint'(done), 1);
        chk(busy == 1'b0, "R10", "busy low at done", longint'(busy), 0);
        chk(err == exp_err, exp_err ? "R5" : "R12", "err at done", longint'(err), longint'(exp_err));
        if (exp_err) begin
            chk(lat >= TMO && lat <= TMO + 10, "R5", "timeout latency", lat, TMO);
        end else if (ne > 0 && vco != 0) begin
            if (crawl)
                chk(lock_w && ack_w, "R4", "lock and ack before release", longint'(lock_w && ack_w), 1);
            else
                chk(lock_w, "R8", "lock before done", longint'(lock_w), 1);
        end
        @(negedge clk);
        chk(done == 1'b0, "R10", "done single pulse", longint'(done), 0);
        chk(wcnt == ne, tag, "write count", wcnt, ne);
        for (int k = 0; k < ne && k < wcnt; k++) begin
            chk(wlog[k] == e[k], tag, "write word", longint'(wlog[k]), longint'(e[k]));
        end
        if (crawl && wcnt >= 2) begin
            chk(wlog[1][23] && wlog[1][31], "R1", "request and enable bits", longint'(wlog[1]), longint'(e[1]));
        end
        if (ne > 0 && vco != 0 && wcnt == ne) begin
            chk(int'(wlog[ne-1][7:0]) == ratio, "R2", "multiplier field", longint'(wlog[ne-1][7:0]), ratio);
        end
        chk(int'(cur_vco) == vco, "R9", "current vco", longint'(cur_vco), vco);
        chk(err == exp_err, "R12", "err held after done", longint'(err), longint'(exp_err));
        if (dup) begin
            bad = 0;
            repeat (10) begin
                @(negedge clk);
                if (done || busy) bad++;
            end
            chk(bad == 0, "R11", "no second operation", bad, 0);
        end
        m_vco   = vco;
        m_cdclk = cdclk;
        m_ref   = rf;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R10 watchdog expired: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R13", "reset busy", longint'(busy), 0);
        chk(done == 1'b0, "R13", "reset done", longint'(done), 0);
        chk(err == 1'b0, "R13", "reset err", longint'(err), 0);
        chk(pll_wr_en == 1'b0, "R13", "reset write strobe", longint'(pll_wr_en), 0);
        chk(cur_vco == '0, "R13", "reset cur_vco", longint'(cur_vco), 0);

        for (int en = 0; en < 2; en++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    run_op(cv[i], cc[i], cr[i], en[0], 1'b0, 1'b0);
                    run_op(cv[j], cc[j], cr[j], en[0], 1'b0, 1'b0);
                end
            end
        end

        run_op(cv[1], cc[1], cr[1], 1'b1, 1'b0, 1'b0);
        run_op(cv[2], cc[2], cr[2], 1'b1, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        chk(err == 1'b1, "R12", "err persists while idle", longint'(err), 1);
        run_op(cv[4], cc[4], cr[4], 1'b1, 1'b0, 1'b0);
        run_op(cv[1], cc[1], cr[1], 1'b0, 1'b1, 1'b0);
        run_op(cv[3], cc[3], cr[3], 1'b1, 1'b0, 1'b0);
        run_op(cv[6], cc[6], cr[6], 1'b1, 1'b0, 1'b1);
        run_op(cv[0], cc[0], cr[0], 1'b1, 1'b0, 1'b1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule